// File: doc/BRIEF.md
# NAND Flash Strobe Controller

This block sits between a simple register-mapped host port and one 8-bit NAND flash device. The host programs a configuration word holding an enable bit, a chip-deselect bit and three timing fields. Each flash bus cycle is then started by a single host access. Writing the command register sends a byte with the command latch strobe high. Writing the address register sends a byte with the address latch strobe high. A data-register write sends a plain byte, and a data-register read fetches one byte from the device.

Every flash cycle runs through three phases, and each phase length is programmed as a cycle count minus one. The setup phase comes first, with the bus and latch strobes set up. The active pulse follows, with the write or read strobe low. The hold phase comes last. The host port is held off until the hold phase has ended, so a host can issue data accesses one after another with no polling. The chip-enable line is a plain software bit that no access touches. The device's ready/busy pin is synchronised and can be read from a status register.

Top module: `nfc_ctrl`

## Requirements
- R1: After reset the write and read strobes are high, both latch strobes are low, the data bus is not driven, chip-enable is high, the configuration reads 0x0800 and no flash cycle runs.
- R2: The configuration register at offset 0x00 holds the enable bit at 15, the chip-deselect bit at 11 (1 deselects), setup at [9:8], pulse at [6:4] and hold at [2:0]. All other bits, including bit 12, read back as 0.
- R3: A write to offset 0x04 while enabled runs one flash write cycle that carries wdata[7:0]. The command latch strobe is high for the whole cycle and the address latch strobe stays low.
- R4: A write to offset 0x08 while enabled runs one flash write cycle that carries wdata[7:0]. The address latch strobe is high for the whole cycle and the command latch strobe stays low.
- R5: While enabled, a write to offset 0x0C runs a write cycle with both latch strobes low. A read of 0x0C runs a read cycle and returns, in rdata[7:0], the device byte present on the last clock of the pulse phase.
- R6: The setup phase lasts setup+1 cycles, the pulse phase pulse+1 cycles and the hold phase hold+1 cycles. The write or read strobe is low only in the pulse phase. In a write, the data bus is driven and stable from the first setup cycle to the last hold cycle.
- R7: Bit 0 of the status register at offset 0x10 shows the ready/busy pin (1 = ready) after a two-flop synchroniser. All other status bits read 0.
- R8: host_ready rises at the clock edge that ends the hold phase, so an access takes setup+pulse+hold+4 cycles from request to ready. Register-only accesses take 1 cycle. host_ready stays high for one cycle only.
- R9: While the enable bit is 0, no strobe moves. Command, address and data accesses complete in one cycle without a flash cycle, and a data read returns 0.
- R10: Chip-enable follows the inverse of nothing but the deselect bit while enabled, and is forced high while the enable bit is 0.
- R11: The write and read strobes are never low together, and the data bus is never driven while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | HDATA_W | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | HDATA_W | Read data, valid with host_ready |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb | input | 1 | Device ready/busy, 1 = ready |

## Verification
The bench uses the all-zero timing setting, where every phase lasts one cycle, and the all-ones setting, where the counters wrap. A counter that is off by one shows up there as a wrong phase length or a wrong host latency. During each read pulse the device model changes the byte it drives on every cycle. A design that captures on the first pulse clock instead of the last therefore returns a different byte. Reserved configuration bits, bit 12 among them, are written as ones. A design that keeps them shows them on readback. With the enable bit cleared, command and data accesses must finish at once with no strobe activity. A design that still starts a cycle shows up as a strobe the scoreboard did not expect.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int BYTE_W  = 8;
  localparam int SETUP_W = 2;
  localparam int PULSE_W = 3;
  localparam int HOLD_W  = 3;
  localparam int MAX_SP  = (SETUP_W > PULSE_W) ? SETUP_W : PULSE_W;
  localparam int CNT_W   = (HOLD_W > MAX_SP) ? HOLD_W : MAX_SP;

  // configuration field positions (host-visible layout)
  localparam int BIT_ON    = 15;
  localparam int BIT_DESEL = 11;
  localparam int SU_LSB    = 8;
  localparam int PW_LSB    = 4;
  localparam int HD_LSB    = 0;

  // register word index = byte offset / 4
  localparam logic [2:0] W_CFG  = 3'd0;
  localparam logic [2:0] W_CMD  = 3'd1;
  localparam logic [2:0] W_ADR  = 3'd2;
  localparam logic [2:0] W_DAT  = 3'd3;
  localparam logic [2:0] W_STAT = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {XF_CMD, XF_ADDR, XF_WDATA, XF_RDATA} xfer_e;

  typedef struct packed {
    logic               on;
    logic               desel;
    logic [SETUP_W-1:0] tsu;
    logic [PULSE_W-1:0] tpw;
    logic [HOLD_W-1:0]  thd;
  } timing_cfg_t;
endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_in,
  output logic rb_out
);
  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= rb_in;
      end
      assign rb_out = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], rb_in};
      end
      assign rb_out = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/nfc_cfg_reg.sv
module nfc_cfg_reg
  import nfc_pkg::*;
#(
  parameter int HDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [HDATA_W-1:0] wdata,
  output timing_cfg_t        cfg,
  output logic [HDATA_W-1:0] readback,
  output logic               ce_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.on    <= 1'b0;
      cfg.desel <= 1'b1;
      cfg.tsu   <= '0;
      cfg.tpw   <= '0;
      cfg.thd   <= '0;
      ce_n      <= 1'b1;
    end else if (wr_en) begin
      cfg.on    <= wdata[BIT_ON];
      cfg.desel <= wdata[BIT_DESEL];
      cfg.tsu   <= wdata[SU_LSB +: SETUP_W];
      cfg.tpw   <= wdata[PW_LSB +: PULSE_W];
      cfg.thd   <= wdata[HD_LSB +: HOLD_W];
      ce_n      <= wdata[BIT_DESEL] | ~wdata[BIT_ON];
    end
  end

  always_comb begin
    readback                    = '0;
    readback[BIT_ON]            = cfg.on;
    readback[BIT_DESEL]         = cfg.desel;
    readback[SU_LSB +: SETUP_W] = cfg.tsu;
    readback[PW_LSB +: PULSE_W] = cfg.tpw;
    readback[HD_LSB +: HOLD_W]  = cfg.thd;
  end

  // R10
  ce_off_chk: assert property (@(posedge clk) disable iff (rst) !cfg.on |-> ce_n);
endmodule

// File: rtl/nfc_phase_seq.sv
module nfc_phase_seq
  import nfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  xfer_e              kind_in,
  input  logic [BYTE_W-1:0]  wbyte,
  input  logic [SETUP_W-1:0] tsu,
  input  logic [PULSE_W-1:0] tpw,
  input  logic [HOLD_W-1:0]  thd,
  input  logic [BYTE_W-1:0]  dq_in,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic               dq_oe,
  output logic [BYTE_W-1:0]  dq_out,
  output logic [BYTE_W-1:0]  rbyte,
  output logic               done
);
  phase_e           ph, ph_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  xfer_e            kind_q, kind_nx;

  assign kind_nx = start ? kind_in : kind_q;
  assign done    = (ph == PH_HOLD) && (cnt == '0);

  always_comb begin
    ph_nx  = ph;
    cnt_nx = cnt;
    case (ph)
      PH_IDLE:  if (start) begin ph_nx = PH_SETUP; cnt_nx = CNT_W'(tsu); end
      PH_SETUP: if (cnt == '0) begin ph_nx = PH_PULSE; cnt_nx = CNT_W'(tpw); end
                else cnt_nx = cnt - 1'b1;
      PH_PULSE: if (cnt == '0) begin ph_nx = PH_HOLD; cnt_nx = CNT_W'(thd); end
                else cnt_nx = cnt - 1'b1;
      default:  if (cnt == '0) ph_nx = PH_IDLE;
                else cnt_nx = cnt - 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      kind_q <= XF_CMD;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_oe  <= 1'b0;
      dq_out <= '0;
      rbyte  <= '0;
    end else begin
      ph     <= ph_nx;
      cnt    <= cnt_nx;
      kind_q <= kind_nx;
      cle    <= (ph_nx != PH_IDLE) && (kind_nx == XF_CMD);
      ale    <= (ph_nx != PH_IDLE) && (kind_nx == XF_ADDR);
      we_n   <= !((ph_nx == PH_PULSE) && (kind_nx != XF_RDATA));
      re_n   <= !((ph_nx == PH_PULSE) && (kind_nx == XF_RDATA));
      dq_oe  <= (ph_nx != PH_IDLE) && (kind_nx != XF_RDATA);
      if (start) dq_out <= wbyte;
      if ((ph == PH_PULSE) && (cnt == '0) && (kind_q == XF_RDATA)) rbyte <= dq_in;
    end
  end

  // length of the current low strobe, for the pulse-width check
  logic [PULSE_W:0] lo_len;
  always_ff @(posedge clk) begin
    if (rst)                 lo_len <= '0;
    else if (!we_n || !re_n) lo_len <= lo_len + 1'b1;
    else                     lo_len <= '0;
  end

  // R11
  we_re_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  // R11
  re_oe_excl_chk: assert property (@(posedge clk) disable iff (rst) !re_n |-> !dq_oe);
  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    ((lo_len != '0) && we_n && re_n) |-> (lo_len == ({1'b0, tpw} + 1'b1)));
  // R6
  dq_stable_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |=> (!dq_oe || $stable(dq_out)));
endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int HDATA_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  output logic               host_ready,
  output logic [HDATA_W-1:0] host_rdata,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic               nand_ce_n,
  output logic [BYTE_W-1:0]  nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [BYTE_W-1:0]  nand_dq_in,
  input  logic               nand_rb
);
  localparam int WORD_W = ADDR_W - 2;

  timing_cfg_t        cfg;
  logic [HDATA_W-1:0] cfg_rd;
  logic               rb_s;
  logic               pend, pend_rd;
  logic               seq_done;
  logic [BYTE_W-1:0]  seq_rbyte;

  logic [WORD_W-1:0] word;
  logic              aligned, take, hit_cfg, hit_stat, is_flash, cfg_we, seq_start;
  xfer_e             kind;

  assign word     = host_addr[ADDR_W-1:2];
  assign aligned  = (host_addr[1:0] == 2'b00);
  assign take     = host_valid && !host_ready && !pend;
  assign hit_cfg  = aligned && (word == WORD_W'(W_CFG));
  assign hit_stat = aligned && (word == WORD_W'(W_STAT));

  always_comb begin
    is_flash = 1'b0;
    kind     = XF_CMD;
    if (aligned) begin
      if (word == WORD_W'(W_CMD) && host_write) begin is_flash = 1'b1; kind = XF_CMD; end
      if (word == WORD_W'(W_ADR) && host_write) begin is_flash = 1'b1; kind = XF_ADDR; end
      if (word == WORD_W'(W_DAT)) begin
        is_flash = 1'b1;
        kind     = host_write ? XF_WDATA : XF_RDATA;
      end
    end
  end

  assign cfg_we    = take && host_write && hit_cfg;
  assign seq_start = take && is_flash && cfg.on;

  nfc_cfg_reg #(.HDATA_W(HDATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wdata(host_wdata),
    .cfg(cfg), .readback(cfg_rd), .ce_n(nand_ce_n)
  );

  nfc_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rb_in(nand_rb), .rb_out(rb_s)
  );

  nfc_phase_seq u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .kind_in(kind),
    .wbyte(host_wdata[BYTE_W-1:0]), .tsu(cfg.tsu), .tpw(cfg.tpw), .thd(cfg.thd),
    .dq_in(nand_dq_in), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_oe(nand_dq_oe), .dq_out(nand_dq_out),
    .rbyte(seq_rbyte), .done(seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ready <= 1'b0;
      host_rdata <= '0;
      pend       <= 1'b0;
      pend_rd    <= 1'b0;
    end else if (host_ready) begin
      host_ready <= 1'b0;
    end else if (pend) begin
      if (seq_done) begin
        pend       <= 1'b0;
        host_ready <= 1'b1;
        host_rdata <= pend_rd ? HDATA_W'(seq_rbyte) : '0;
      end
    end else if (host_valid) begin
      if (seq_start) begin
        pend    <= 1'b1;
        pend_rd <= (kind == XF_RDATA);
      end else begin
        host_ready <= 1'b1;
        if (hit_cfg)       host_rdata <= cfg_rd;
        else if (hit_stat) host_rdata <= HDATA_W'(rb_s);
        else               host_rdata <= '0;
      end
    end
  end

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (nand_cle || nand_ale || !nand_we_n || !nand_re_n || nand_dq_oe) |-> cfg.on);
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
  // R8
  ready_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale));
endmodule

// File: tb/tb_nfc_ctrl.sv
module tb_nfc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready;
  logic [15:0] host_rdata;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  always #2 clk = ~clk;

  nfc_ctrl dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb)
  );

  typedef struct { int kind; int b; int s; int p; int h; } item_t;
  item_t exp_q[$];

  int checks = 0, errors = 0;
  int cur_s = 0, cur_p = 0, cur_h = 0;
  logic [7:0] rd_base = 8'h40;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: rebuilds each flash cycle from the pins and compares to the queue
  initial begin
    int ws = 0, wp = 0, wh = 0, wb = 0, wc = 0, wa = 0;
    int rp = 0, rc = 0, ra = 0;
    bit w_act = 0, r_act = 0;
    item_t e;
    forever begin
      @(negedge clk);
      if (nand_dq_oe) begin
        w_act = 1;
        if (!nand_we_n) begin wp++; wb = nand_dq_out; wc = nand_cle; wa = nand_ale; end
        else if (wp == 0) ws++;
        else wh++;
      end else if (w_act) begin
        if (exp_q.size() == 0) chk(0, "R9", "unexpected write cycle", wb, 0);
        else begin
          e = exp_q.pop_front();
          chk(e.kind == (wc ? 0 : (wa ? 1 : 2)), "R3 R4 R5", "cycle kind", wc*2+wa, e.kind);
          chk(wb == e.b, "R3 R4 R5", "bus byte", wb, e.b);
          chk(ws == e.s && wp == e.p && wh == e.h, "R6", "setup/pulse/hold",
              ws*256+wp*16+wh, e.s*256+e.p*16+e.h);
        end
        w_act = 0; ws = 0; wp = 0; wh = 0;
      end
      if (!nand_re_n) begin
        r_act = 1; rp++; rc = nand_cle; ra = nand_ale;
        nand_dq_in = rd_base + 8'(rp);
      end else begin
        nand_dq_in = rd_base;
        if (r_act) begin
          if (exp_q.size() == 0) chk(0, "R9", "unexpected read cycle", rp, 0);
          else begin
            e = exp_q.pop_front();
            chk(e.kind == 3 && rc == 0 && ra == 0, "R5", "read cycle kind", e.kind, 3);
            chk(rp == e.p, "R6", "read pulse length", rp, e.p);
          end
          r_act = 0; rp = 0;
        end
      end
    end
  end

  // driver: one host access, called and returning at a falling edge
  task automatic bus(input logic wr, input logic [4:0] a, input logic [15:0] d,
                     input int lat, output logic [15:0] rd, input string req);
    int n = 0;
    host_valid = 1; host_write = wr; host_addr = a; host_wdata = d;
    do begin @(negedge clk); n++; end while (!host_ready && n < 300);
    chk(n == lat, req, "host latency", n, lat);
    rd = host_rdata;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic set_cfg(input int on, input int desel, input int s, input int p, input int h, input int extra);
    logic [15:0] v, rd;
    v = 16'((on << 15) | (desel << 11) | (s << 8) | (p << 4) | h);
    bus(1, 5'h00, v | 16'(extra), 1, rd, "R2");
    bus(0, 5'h00, 16'h0, 1, rd, "R2");
    chk(rd == v, "R2", "config readback", rd, v);
    cur_s = s; cur_p = p; cur_h = h;
  endtask

  task automatic flash_wr(input int kind, input int b, input string req);
    item_t e;
    logic [15:0] rd;
    logic [4:0] a;
    e.kind = kind; e.b = b; e.s = cur_s + 1; e.p = cur_p + 1; e.h = cur_h + 1;
    exp_q.push_back(e);
    a = (kind == 0) ? 5'h04 : ((kind == 1) ? 5'h08 : 5'h0C);
    bus(1, a, 16'(b) | 16'hA500, cur_s + cur_p + cur_h + 4, rd, req);
  endtask

  task automatic flash_rd(input logic [7:0] base);
    item_t e;
    logic [15:0] rd, ex;
    rd_base = base;
    e.kind = 3; e.b = 0; e.s = cur_s + 1; e.p = cur_p + 1; e.h = cur_h + 1;
    exp_q.push_back(e);
    bus(0, 5'h0C, 16'h0, cur_s + cur_p + cur_h + 4, rd, "R8");
    ex = 16'(8'(base + 8'(cur_p + 1)));
    chk(rd == ex, "R5", "read byte (last pulse clock)", rd, ex);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe, "R1", "strobes idle",
        {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
    chk(nand_ce_n == 1, "R1", "chip enable high", nand_ce_n, 1);
    bus(0, 5'h00, 16'h0, 1, rd, "R1");
    chk(rd == 16'h0800, "R1", "config after reset", rd, 16'h0800);
    // R9 disabled after reset: no flash cycle
    bus(1, 5'h04, 16'h00FF, 1, rd, "R9");

    // R2 reserved bits (incl. 12) read 0; R10 chip enable low
    set_cfg(1, 0, 1, 2, 3, 16'h7088);
    @(negedge clk);
    chk(nand_ce_n == 0, "R10", "ce_n when selected", nand_ce_n, 0);
    flash_wr(0, 8'h90, "R3");
    flash_wr(1, 8'h00, "R4");
    flash_wr(2, 8'hA5, "R5");
    flash_rd(8'h10);

    // minimum timing, back-to-back data
    set_cfg(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) flash_wr(2, 8'h31 + i, "R8");
    flash_rd(8'h80);

    // maximum timing
    set_cfg(1, 0, 3, 7, 7, 0);
    flash_wr(0, 8'h70, "R3");
    flash_wr(1, 8'hC3, "R4");
    flash_rd(8'hF0);

    // R7 status
    nand_rb = 0; repeat (4) @(negedge clk);
    bus(0, 5'h10, 16'h0, 1, rd, "R7");
    chk(rd == 16'h0000, "R7", "status busy", rd, 0);
    nand_rb = 1; repeat (4) @(negedge clk);
    bus(0, 5'h10, 16'h0, 1, rd, "R7");
    chk(rd == 16'h0001, "R7", "status ready", rd, 1);

    // R10 deselect bit while enabled
    set_cfg(1, 1, 0, 1, 0, 0);
    @(negedge clk);
    chk(nand_ce_n == 1, "R10", "ce_n deselected", nand_ce_n, 1);

    // R9 disabled: immediate completion, no strobes, zero read
    set_cfg(0, 0, 0, 1, 0, 0);
    @(negedge clk);
    chk(nand_ce_n == 1, "R10", "ce_n forced high when off", nand_ce_n, 1);
    bus(1, 5'h04, 16'h00AA, 1, rd, "R9");
    bus(1, 5'h08, 16'h0055, 1, rd, "R9");
    bus(1, 5'h0C, 16'h0033, 1, rd, "R9");
    rd_base = 8'h77;
    bus(0, 5'h0C, 16'h0, 1, rd, "R9");
    chk(rd == 16'h0, "R9", "data read while off", rd, 0);
    repeat (3) @(negedge clk);

    // back on
    set_cfg(1, 0, 2, 1, 2, 0);
    flash_wr(2, 8'h5A, "R6");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "expected cycles left unseen", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule